// File: doc/BRIEF.md
# Dual-Select Fixed-Point FFT Butterfly

This block performs one radix-2 decimation-in-time butterfly per clock. It produces X0 = a + w·b and X1 = a − w·b, where the twiddle is w = cos θ − j·sin θ and θ = π·idx / 2^IDX_W. The arithmetic uses only fused multiply-add steps. The twiddle product is split into a scale factor and a ratio. An internal table, computed at elaboration, holds a one-bit form selector, the scale and the ratio for every index.

For indices where |cos θ| > |sin θ|, the block uses the cosine form: it scales by cos θ and multiplies by the ratio tan θ. Everywhere else it uses the sine form: it scales by sin θ and multiplies by the ratio cot θ. As a result, no stored ratio exceeds one in magnitude and no division by zero can arise. Both forms run through the same two fused stages; the selector only steers operand multiplexers. Stage one computes the ratio products and stage two the scale products. Each stage rounds once, half-up. The outputs saturate to the data width.

A stream of butterflies is fed with `valid_i`. Each accepted butterfly emerges two clocks later with `valid_o` set, and a new one can enter every cycle.

Top module: `dsfma_butterfly`

## Requirements
- R1: While `rst_ni` is low, and until the first result appears, `valid_o` is 0 and all four result outputs are 0.
- R2: For every index, each output component lies within 2 LSB of the correctly rounded, saturated value of a ± w·b.
- R3: A butterfly accepted with `valid_i` = 1 at a rising edge appears on the outputs, with `valid_o` = 1, after the second following rising edge. Back-to-back butterflies are accepted every cycle.
- R4: The table selects the cosine form when |cos θ| > |sin θ| and the sine form otherwise. Index 0 uses the cosine form, index 2^(IDX_W−1) uses the sine form, and every stored ratio lies within [−1.0, +1.0].
- R5: At index 0 the outputs are exactly a + b and a − b. At index 2^(IDX_W−1) (w = −j) they are exactly X0 = (ar + bi, ai − br) and X1 = (ar − bi, ai + br).
- R6: An output component whose value lies outside the signed DATA_W range is clamped to 2^(DATA_W−1) − 1 or −2^(DATA_W−1).
- R7: In any cycle where `valid_o` is 0, the result outputs keep the values of the last valid result.
- R8: Inputs presented with `valid_i` = 0 produce no `valid_o` pulse and do not change the result outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Butterfly operands present |
| idx_i | input | IDX_W | Twiddle index, θ = π·idx/2^IDX_W |
| a_re_i | input | DATA_W | Real part of a, signed |
| a_im_i | input | DATA_W | Imaginary part of a, signed |
| b_re_i | input | DATA_W | Real part of b, signed |
| b_im_i | input | DATA_W | Imaginary part of b, signed |
| valid_o | output | 1 | Result present |
| x0_re_o | output | DATA_W | Real part of a + w·b |
| x0_im_o | output | DATA_W | Imaginary part of a + w·b |
| x1_re_o | output | DATA_W | Real part of a − w·b |
| x1_im_o | output | DATA_W | Imaginary part of a − w·b |

## Verification
A wrong table entry shows up two cycles after its index is presented. A wrong form selector, scale or ratio makes all four outputs of that butterfly miss the reference by far more than 2 LSB. Because of this, every index is swept at least once. A swapped operand multiplexer breaks the exact results at index 0 and at the quarter turn in the same two cycles. A broken valid pipeline or register enable shows either as a `valid_o` pulse that is misplaced by a cycle, or as outputs that move during idle cycles, and the latter is seen on the very next idle cycle.

// File: rtl/dsfma_pkg.sv
package dsfma_pkg;
  localparam int DEF_DATA_W    = 16;
  localparam int DEF_COEF_W    = 18;
  localparam int DEF_COEF_FRAC = 16;
  localparam int DEF_IDX_W     = 5;

  typedef enum logic {
    MODE_SIN = 1'b0,
    MODE_COS = 1'b1
  } mode_e;
endpackage

// File: rtl/dsfma_fma.sv
// res = sat(round_half_up((add << FRAC) +/- coef*mul) >> FRAC)
module dsfma_fma #(
  parameter int COEF_W = 18,
  parameter int MUL_W  = 17,
  parameter int ADD_W  = 17,
  parameter int FRAC   = 16,
  parameter int OUT_W  = 18
) (
  input  logic signed [COEF_W-1:0] coef_i,
  input  logic signed [MUL_W-1:0]  mul_i,
  input  logic signed [ADD_W-1:0]  add_i,
  input  logic                     neg_i,
  output logic signed [OUT_W-1:0]  res_o
);
  localparam int PW    = COEF_W + MUL_W;
  localparam int SW    = ADD_W + FRAC;
  localparam int ACC_W = ((PW > SW) ? PW : SW) + 2;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC - 1);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

  logic signed [PW-1:0]    prod;
  logic signed [ACC_W-1:0] prod_x, add_x, acc, rnd_q;

  always_comb begin
    prod   = coef_i * mul_i;
    prod_x = ACC_W'(prod);
    add_x  = ACC_W'(add_i) <<< FRAC;
    acc    = add_x + (neg_i ? -prod_x : prod_x) + HALF;
    rnd_q  = acc >>> FRAC;
    if (rnd_q > MAXV)      res_o = MAXV[OUT_W-1:0];
    else if (rnd_q < MINV) res_o = MINV[OUT_W-1:0];
    else                   res_o = rnd_q[OUT_W-1:0];
  end
endmodule

// File: rtl/dsfma_twiddle_rom.sv
// Per index: form selector, scale, ratio (|ratio| <= 1). Built at elaboration.
module dsfma_twiddle_rom import dsfma_pkg::*; #(
  parameter int IDX_W     = DEF_IDX_W,
  parameter int COEF_W    = DEF_COEF_W,
  parameter int COEF_FRAC = DEF_COEF_FRAC
) (
  input  logic [IDX_W-1:0]         idx_i,
  output mode_e                    mode_o,
  output logic signed [COEF_W-1:0] scale_o,
  output logic signed [COEF_W-1:0] ratio_o
);
  localparam int  N   = 1 << IDX_W;
  localparam real PI  = 3.14159265358979323846;
  localparam real ONE = 2.0 ** COEF_FRAC;

  function automatic int quant(input real x);
    real y;
    y = x * ONE;
    return (y >= 0.0) ? $rtoi(y + 0.5) : -$rtoi(0.5 - y);
  endfunction

  logic [N-1:0]             mode_tab;
  logic signed [COEF_W-1:0] scale_tab [N];
  logic signed [COEF_W-1:0] ratio_tab [N];

  for (genvar k = 0; k < N; k++) begin : g_ent
    localparam real TH      = PI * real'(k) / real'(N);
    localparam real CV      = $cos(TH);
    localparam real SV      = $sin(TH);
    localparam real CA      = (CV < 0.0) ? -CV : CV;
    localparam bit  USE_COS = CA > SV;
    localparam real SC      = USE_COS ? CV : SV;
    localparam real RT      = USE_COS ? SV / ((CV == 0.0) ? 1.0 : CV)
                                      : CV / ((SV == 0.0) ? 1.0 : SV);
    assign mode_tab[k]  = USE_COS;
    assign scale_tab[k] = COEF_W'(quant(SC));
    assign ratio_tab[k] = COEF_W'(quant(RT));
  end

  assign mode_o  = mode_e'(mode_tab[idx_i]);
  assign scale_o = scale_tab[idx_i];
  assign ratio_o = ratio_tab[idx_i];
endmodule

// File: rtl/dsfma_ratio_stage.sv
// Stage 1: sine form u = t*br + bi, v = t*bi - br; cosine form u = br + t*bi, v = bi - t*br
module dsfma_ratio_stage import dsfma_pkg::*; #(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int COEF_W    = DEF_COEF_W,
  parameter int COEF_FRAC = DEF_COEF_FRAC,
  localparam int OP_W     = DATA_W + 1,
  localparam int UV_W     = DATA_W + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  mode_e                    mode_i,
  input  logic signed [COEF_W-1:0] scale_i,
  input  logic signed [COEF_W-1:0] ratio_i,
  input  logic signed [DATA_W-1:0] ar_i,
  input  logic signed [DATA_W-1:0] ai_i,
  input  logic signed [DATA_W-1:0] br_i,
  input  logic signed [DATA_W-1:0] bi_i,
  output logic                     valid_o,
  output logic signed [COEF_W-1:0] scale_o,
  output logic signed [DATA_W-1:0] ar_o,
  output logic signed [DATA_W-1:0] ai_o,
  output logic signed [UV_W-1:0]   u_o,
  output logic signed [UV_W-1:0]   v_o
);
  logic signed [OP_W-1:0] br_x, bi_x, xu, yu, xv, yv;
  logic signed [UV_W-1:0] u_d, v_d;

  always_comb begin
    br_x = OP_W'(br_i);
    bi_x = OP_W'(bi_i);
    if (mode_i == MODE_SIN) begin
      xu = br_x;  yu = bi_x;
      xv = bi_x;  yv = -br_x;
    end else begin
      xu = bi_x;  yu = br_x;
      xv = -br_x; yv = bi_x;
    end
  end

  dsfma_fma #(
    .COEF_W(COEF_W), .MUL_W(OP_W), .ADD_W(OP_W), .FRAC(COEF_FRAC), .OUT_W(UV_W)
  ) i_fma_u (
    .coef_i(ratio_i), .mul_i(xu), .add_i(yu), .neg_i(1'b0), .res_o(u_d)
  );

  dsfma_fma #(
    .COEF_W(COEF_W), .MUL_W(OP_W), .ADD_W(OP_W), .FRAC(COEF_FRAC), .OUT_W(UV_W)
  ) i_fma_v (
    .coef_i(ratio_i), .mul_i(xv), .add_i(yv), .neg_i(1'b0), .res_o(v_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scale_o <= '0;
      ar_o    <= '0;
      ai_o    <= '0;
      u_o     <= '0;
      v_o     <= '0;
    end else if (valid_i) begin
      scale_o <= scale_i;
      ar_o    <= ar_i;
      ai_o    <= ai_i;
      u_o     <= u_d;
      v_o     <= v_d;
    end
  end
endmodule

// File: rtl/dsfma_scale_stage.sv
// Stage 2: lane 0 ar+s*u, lane 1 ai+s*v, lane 2 ar-s*u, lane 3 ai-s*v
module dsfma_scale_stage import dsfma_pkg::*; #(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int COEF_W    = DEF_COEF_W,
  parameter int COEF_FRAC = DEF_COEF_FRAC,
  localparam int UV_W     = DATA_W + 2,
  localparam int LANES    = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [COEF_W-1:0] scale_i,
  input  logic signed [DATA_W-1:0] ar_i,
  input  logic signed [DATA_W-1:0] ai_i,
  input  logic signed [UV_W-1:0]   u_i,
  input  logic signed [UV_W-1:0]   v_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] x0_re_o,
  output logic signed [DATA_W-1:0] x0_im_o,
  output logic signed [DATA_W-1:0] x1_re_o,
  output logic signed [DATA_W-1:0] x1_im_o
);
  logic signed [DATA_W-1:0] res_d [LANES];
  logic signed [DATA_W-1:0] res_q [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam bit IS_IM  = (i % 2) == 1;
    localparam bit IS_NEG = (i / 2) == 1;
    logic signed [UV_W-1:0]   mul;
    logic signed [DATA_W-1:0] add;
    assign mul = IS_IM ? v_i : u_i;
    assign add = IS_IM ? ai_i : ar_i;

    dsfma_fma #(
      .COEF_W(COEF_W), .MUL_W(UV_W), .ADD_W(DATA_W), .FRAC(COEF_FRAC), .OUT_W(DATA_W)
    ) i_fma (
      .coef_i(scale_i), .mul_i(mul), .add_i(add), .neg_i(IS_NEG), .res_o(res_d[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      res_q[i] <= '0;
      else if (valid_i) res_q[i] <= res_d[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  assign x0_re_o = res_q[0];
  assign x0_im_o = res_q[1];
  assign x1_re_o = res_q[2];
  assign x1_im_o = res_q[3];
endmodule

// File: rtl/dsfma_butterfly.sv
module dsfma_butterfly import dsfma_pkg::*; #(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int COEF_W    = DEF_COEF_W,
  parameter int COEF_FRAC = DEF_COEF_FRAC,
  parameter int IDX_W     = DEF_IDX_W,
  localparam int UV_W     = DATA_W + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic signed [DATA_W-1:0] a_re_i,
  input  logic signed [DATA_W-1:0] a_im_i,
  input  logic signed [DATA_W-1:0] b_re_i,
  input  logic signed [DATA_W-1:0] b_im_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] x0_re_o,
  output logic signed [DATA_W-1:0] x0_im_o,
  output logic signed [DATA_W-1:0] x1_re_o,
  output logic signed [DATA_W-1:0] x1_im_o
);
  mode_e                    rom_mode;
  logic signed [COEF_W-1:0] rom_scale, rom_ratio;
  logic                     mid_valid;
  logic signed [COEF_W-1:0] mid_scale;
  logic signed [DATA_W-1:0] mid_ar, mid_ai;
  logic signed [UV_W-1:0]   mid_u, mid_v;

  dsfma_twiddle_rom #(
    .IDX_W(IDX_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)
  ) i_rom (
    .idx_i  (idx_i),
    .mode_o (rom_mode),
    .scale_o(rom_scale),
    .ratio_o(rom_ratio)
  );

  dsfma_ratio_stage #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)
  ) i_ratio (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .mode_i (rom_mode),
    .scale_i(rom_scale),
    .ratio_i(rom_ratio),
    .ar_i   (a_re_i),
    .ai_i   (a_im_i),
    .br_i   (b_re_i),
    .bi_i   (b_im_i),
    .valid_o(mid_valid),
    .scale_o(mid_scale),
    .ar_o   (mid_ar),
    .ai_o   (mid_ai),
    .u_o    (mid_u),
    .v_o    (mid_v)
  );

  dsfma_scale_stage #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)
  ) i_scale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(mid_valid),
    .scale_i(mid_scale),
    .ar_i   (mid_ar),
    .ai_i   (mid_ai),
    .u_i    (mid_u),
    .v_i    (mid_v),
    .valid_o(valid_o),
    .x0_re_o(x0_re_o),
    .x0_im_o(x0_im_o),
    .x1_re_o(x1_re_o),
    .x1_im_o(x1_im_o)
  );
endmodule

// File: rtl/dsfma_butterfly_chk.sv
module dsfma_butterfly_chk import dsfma_pkg::*; #(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int COEF_W    = DEF_COEF_W,
  parameter int COEF_FRAC = DEF_COEF_FRAC,
  parameter int IDX_W     = DEF_IDX_W
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_i,
  input logic [IDX_W-1:0]         idx_i,
  input mode_e                    mode_i,
  input logic signed [COEF_W-1:0] ratio_i,
  input logic                     mid_valid_i,
  input logic                     valid_o,
  input logic signed [DATA_W-1:0] x0_re_o,
  input logic signed [DATA_W-1:0] x0_im_o,
  input logic signed [DATA_W-1:0] x1_re_o,
  input logic signed [DATA_W-1:0] x1_im_o
);
  localparam logic signed [COEF_W-1:0] ONE  = COEF_W'(1) << COEF_FRAC;
  localparam logic [IDX_W-1:0]         QIDX = IDX_W'(1) << (IDX_W - 1);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!valid_o && x0_re_o == 0 && x0_im_o == 0 &&
                                x1_re_o == 0 && x1_im_o == 0)
        else $error("outputs not cleared in reset");
    end
  end

  p_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o);

  p_no_spurious_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##2 !valid_o);

  p_ratio_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (ratio_i <= ONE && ratio_i >= -ONE));

  p_zero_cos_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && idx_i == '0) |-> mode_i == MODE_COS);

  p_quarter_sin_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && idx_i == QIDX) |-> mode_i == MODE_SIN);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mid_valid_i |=> $stable({x0_re_o, x0_im_o, x1_re_o, x1_im_o}));
endmodule

bind dsfma_butterfly dsfma_butterfly_chk #(
  .DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC), .IDX_W(IDX_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .idx_i      (idx_i),
  .mode_i     (rom_mode),
  .ratio_i    (rom_ratio),
  .mid_valid_i(mid_valid),
  .valid_o    (valid_o),
  .x0_re_o    (x0_re_o),
  .x0_im_o    (x0_im_o),
  .x1_re_o    (x1_re_o),
  .x1_im_o    (x1_im_o)
);

// File: tb/test_dsfma_butterfly.sv
module test_dsfma_butterfly;
  localparam int  DATA_W = 16;
  localparam int  IDX_W  = 5;
  localparam int  N      = 1 << IDX_W;
  localparam int  DMAX   = (1 << (DATA_W - 1)) - 1;
  localparam int  DMIN   = -(1 << (DATA_W - 1));
  localparam real PI     = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [IDX_W-1:0] idx_i = '0;
  logic signed [DATA_W-1:0] a_re_i = '0, a_im_i = '0, b_re_i = '0, b_im_i = '0;
  logic valid_o;
  logic signed [DATA_W-1:0] x0_re_o, x0_im_o, x1_re_o, x1_im_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dsfma_butterfly i_dsfma_butterfly (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .idx_i(idx_i),
    .a_re_i(a_re_i), .a_im_i(a_im_i), .b_re_i(b_re_i), .b_im_i(b_im_i),
    .valid_o(valid_o), .x0_re_o(x0_re_o), .x0_im_o(x0_im_o),
    .x1_re_o(x1_re_o), .x1_im_o(x1_im_o)
  );

  // two-deep expectation pipeline, index 1 is due on the outputs now
  bit    pv  [2];
  int    pe  [2][4];
  int    ptl [2];
  string prq [2];
  int    last [4];

  task automatic chk(input string req, input string what, input int act, input int exp, input int tol);
    int d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sat_rnd(input real x);
    int r;
    r = $rtoi($floor(x + 0.5));
    if (r > DMAX) r = DMAX;
    if (r < DMIN) r = DMIN;
    return r;
  endfunction

  task automatic monitor();
    int act [4];
    act[0] = int'(x0_re_o); act[1] = int'(x0_im_o);
    act[2] = int'(x1_re_o); act[3] = int'(x1_im_o);
    if (pv[1]) begin
      chk("R3", "valid_o", int'(valid_o), 1, 0);
      for (int i = 0; i < 4; i++) chk(prq[1], "result", act[i], pe[1][i], ptl[1]);
      for (int i = 0; i < 4; i++) last[i] = act[i];
    end else begin
      chk("R8", "valid_o idle", int'(valid_o), 0, 0);
      for (int i = 0; i < 4; i++) chk("R7", "held result", act[i], last[i], 0);
    end
  endtask

  task automatic step(input bit v, input int idx, input int ar, input int ai,
                      input int br, input int bi, input string req, input int tol);
    real th, c, s, pr, pim;
    @(negedge clk);
    monitor();
    pv[1] = pv[0]; ptl[1] = ptl[0]; prq[1] = prq[0];
    for (int i = 0; i < 4; i++) pe[1][i] = pe[0][i];
    th  = PI * real'(idx) / real'(N);
    c   = $cos(th);
    s   = $sin(th);
    pr  = c * real'(br) + s * real'(bi);
    pim = c * real'(bi) - s * real'(br);
    pv[0] = v; ptl[0] = tol; prq[0] = req;
    pe[0][0] = sat_rnd(real'(ar) + pr);
    pe[0][1] = sat_rnd(real'(ai) + pim);
    pe[0][2] = sat_rnd(real'(ar) - pr);
    pe[0][3] = sat_rnd(real'(ai) - pim);
    valid_i = v;
    idx_i   = IDX_W'(idx);
    a_re_i  = DATA_W'(ar); a_im_i = DATA_W'(ai);
    b_re_i  = DATA_W'(br); b_im_i = DATA_W'(bi);
  endtask

  function automatic int rnd_data();
    return int'($signed(DATA_W'($urandom)));
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2; i++) begin
      pv[i] = 1'b0; ptl[i] = 0; prq[i] = "R1";
      for (int j = 0; j < 4; j++) pe[i][j] = 0;
    end
    for (int i = 0; i < 4; i++) last[i] = 0;

    // R1: reset with active-looking inputs
    valid_i = 1'b1; idx_i = 5; a_re_i = 100; b_re_i = -300;
    repeat (4) @(negedge clk);
    chk("R1", "valid_o in reset", int'(valid_o), 0, 0);
    chk("R1", "x0_re in reset", int'(x0_re_o), 0, 0);
    chk("R1", "x1_im in reset", int'(x1_im_o), 0, 0);
    valid_i = 1'b0;
    rst_ni  = 1'b1;

    // R5: exact at index 0 and at the quarter turn
    step(1, 0, 1000, -2000, 3000, -4000, "R5", 0);
    step(1, N/2, 1234, -567, 890, -321, "R5", 0);
    step(1, 0, -32768, 32767, 12345, -12345, "R5", 0);
    step(1, N/2, 77, 88, -32768, 32767, "R5", 0);
    // R6: saturation both ways
    step(1, 0, 32767, -32768, 32767, -32768, "R6", 0);
    step(1, N/2, 32767, -32768, -32768, 32767, "R6", 0);
    // R8: invalid garbage between, outputs must hold (R7)
    step(0, 7, 5000, 5000, 5000, 5000, "R8", 0);
    step(0, 9, -9000, 1, 2, 3, "R8", 0);
    step(0, 0, 0, 0, 0, 0, "R8", 0);

    // R4: every index back to back, checked to the R2 bound
    for (int k = 0; k < N; k++)
      step(1, k, rnd_data() / 4, rnd_data() / 4, rnd_data(), rnd_data(), "R4", 2);
    for (int k = N - 1; k >= 0; k--)
      step(1, k, rnd_data(), rnd_data(), rnd_data(), rnd_data(), "R4", 2);

    // R2: random stream with gaps
    for (int n = 0; n < 3000; n++) begin
      bit v;
      v = ($urandom % 10) < 7;
      step(v, int'($urandom % N), rnd_data(), rnd_data(), rnd_data(), rnd_data(),
           v ? "R2" : "R8", 2);
    end

    step(0, 0, 0, 0, 0, 0, "R8", 0);
    step(0, 0, 0, 0, 0, 0, "R8", 0);
    step(0, 0, 0, 0, 0, 0, "R8", 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule